// File: doc/BRIEF.md
# Extended Mantissa Denormalizing Shifter

This block moves a wide floating-point mantissa to the right by an unsigned count and raises the exponent by the same count. It is used when an operand must be aligned to a larger exponent, or when a result must be brought into the denormal range. The mantissa is a 64-bit main field. It is followed by an 8-bit guard byte that catches the bits shifted out. Bits that drop below the guard byte are not lost outright. They are folded into bit 0 of the guard byte as a sticky flag, so that a later rounding stage can still tell that the discarded tail was nonzero.

The block treats the count in three bands. For small counts the guard byte is exact. For medium counts the guard byte carries a sticky OR. For very large counts everything collapses into a single "was anything set" bit. The guard byte present on the input is dropped; only the incoming mantissa feeds the result. A single register stage sits between the inputs and the outputs, and the valid flag travels with the data.

Top module: `dnorm_shift_unit`

## Requirements
- R1: One cycle after `in_valid`, `out_exp` equals `in_exp + in_cnt` taken modulo 2^16.
- R2: For counts 0 to 8, the mantissa is shifted right by the count. The guard byte holds the bits shifted out, placed at its top end with the remaining low bits zero. No sticky bit is applied, and count 0 leaves the mantissa unchanged with a zero guard byte.
- R3: For counts 9 to 71, the guard byte is bits [count-1 : count-8] of the original mantissa. Its bit 0 is then ORed with the OR of every original mantissa bit below position count-8.
- R4: For counts 33 to 71, bits [63:32] of the output mantissa are zero, and bits [31:0] equal the original bits [63:32] shifted right by count-32.
- R5: For counts 40 to 71, the sticky flag covers every bit of the original low 32-bit half. A lone set bit anywhere in that half sets guard bit 0.
- R6: For any count of 72 or more, up to 65535, the output mantissa is zero. The guard byte is 1 when any input mantissa bit was set and 0 otherwise.
- R7: The value on `in_guard` has no effect on any output.
- R8: `out_valid` follows `in_valid` by one clock. When `in_valid` is low, the data outputs keep their previous values.
- R9: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_exp | input | 16 | Exponent of the operand |
| in_mant | input | 64 | Mantissa main field |
| in_guard | input | 8 | Incoming guard byte (ignored) |
| in_cnt | input | 16 | Right-shift count |
| out_valid | output | 1 | Result present |
| out_exp | output | 16 | Exponent raised by the count |
| out_mant | output | 64 | Shifted mantissa |
| out_guard | output | 8 | Guard byte with sticky in bit 0 |

## Verification
The bench builds the block with its default parameters: a 64-bit mantissa, an 8-bit guard byte and 16-bit exponent and count. With these values the full 16-bit count range can be driven, so the bench can test every band edge (8/9, 32/33, 39/40, 71/72) as well as counts far past the collapse limit, up to 65535. The expected values come from a one-bit-at-a-time shift model with a running sticky flag, which is a different formulation from the windowed shift in the design.

// File: rtl/dnorm_pkg.sv
package dnorm_pkg;

  // Which treatment a given count receives
  typedef enum logic [1:0] {
    BAND_EXACT    = 2'd0,
    BAND_STICKY   = 2'd1,
    BAND_COLLAPSE = 2'd2
  } dnorm_band_e;

  // Classify a count: exact up to the guard width, sticky below the
  // collapse limit, collapse at or above it.
  function automatic dnorm_band_e pick_band(input int unsigned cnt,
                                            input int unsigned guard_w,
                                            input int unsigned limit);
    if (cnt >= limit)
      return BAND_COLLAPSE;
    else if (cnt > guard_w)
      return BAND_STICKY;
    else
      return BAND_EXACT;
  endfunction

  // Modular exponent adjustment
  function automatic logic [15:0] raise_exp(input logic [15:0] e,
                                            input logic [15:0] c);
    return e + c;
  endfunction

endpackage

// File: rtl/dnorm_window_shift.sv
module dnorm_window_shift #(
  parameter int MW = 64,
  parameter int GW = 8,
  parameter int CW = 16
) (
  input  logic [MW-1:0] mant_i,
  input  logic [CW-1:0] cnt_i,
  output logic [MW-1:0] mant_o,
  output logic [GW-1:0] win_o
);
  localparam int XW = MW + GW;

  logic [XW-1:0] ext;
  logic [XW-1:0] shifted;

  // Append an empty guard window, then shift the whole span.
  // Counts at or past XW yield zero.
  assign ext     = {mant_i, {GW{1'b0}}};
  assign shifted = ext >> cnt_i;
  assign mant_o  = shifted[XW-1:GW];
  assign win_o   = shifted[GW-1:0];
endmodule

// File: rtl/dnorm_lost_bits.sv
module dnorm_lost_bits #(
  parameter int MW = 64,
  parameter int GW = 8,
  parameter int CW = 16
) (
  input  logic [MW-1:0] mant_i,
  input  logic [CW-1:0] cnt_i,
  output logic          sticky_o,
  output logic          any_set_o
);
  logic [MW-1:0] lost;

  // Bit i drops below the guard window once the count exceeds i+GW.
  for (genvar i = 0; i < MW; i++) begin : g_lost
    assign lost[i] = mant_i[i] & (int'(cnt_i) > i + GW);
  end

  assign sticky_o  = |lost;
  assign any_set_o = |mant_i;
endmodule

// File: rtl/dnorm_shift_unit.sv
module dnorm_shift_unit
  import dnorm_pkg::*;
#(
  parameter int MW = 64,
  parameter int GW = 8,
  parameter int EW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [EW-1:0] in_exp,
  input  logic [MW-1:0] in_mant,
  input  logic [GW-1:0] in_guard,
  input  logic [CW-1:0] in_cnt,
  output logic          out_valid,
  output logic [EW-1:0] out_exp,
  output logic [MW-1:0] out_mant,
  output logic [GW-1:0] out_guard
);
  localparam int LIMIT = MW + GW;

  // Named events for the checker
  dnorm_band_e   band;
  logic          band_collapse;
  logic          band_sticky;
  logic          sticky_bit;
  logic          any_set;
  logic [MW-1:0] win_mant;
  logic [GW-1:0] win_bits;
  logic [MW-1:0] next_mant;
  logic [GW-1:0] next_guard;
  logic [EW-1:0] next_exp;
  logic          unused_guard;

  // The incoming guard byte does not take part in the result
  assign unused_guard = ^in_guard;

  assign band          = pick_band(int'(in_cnt), GW, LIMIT);
  assign band_collapse = (band == BAND_COLLAPSE);
  assign band_sticky   = (band == BAND_STICKY);

  dnorm_window_shift #(.MW(MW), .GW(GW), .CW(CW)) u_win (
    .mant_i (in_mant),
    .cnt_i  (in_cnt),
    .mant_o (win_mant),
    .win_o  (win_bits)
  );

  dnorm_lost_bits #(.MW(MW), .GW(GW), .CW(CW)) u_lost (
    .mant_i    (in_mant),
    .cnt_i     (in_cnt),
    .sticky_o  (sticky_bit),
    .any_set_o (any_set)
  );

  always_comb begin
    next_exp = in_exp + EW'(in_cnt);
    unique case (band)
      BAND_COLLAPSE: begin
        next_mant  = '0;
        next_guard = {{(GW-1){1'b0}}, any_set};
      end
      BAND_STICKY: begin
        next_mant  = win_mant;
        next_guard = win_bits | {{(GW-1){1'b0}}, sticky_bit};
      end
      default: begin
        next_mant  = win_mant;
        next_guard = win_bits;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_exp   <= '0;
      out_mant  <= '0;
      out_guard <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_exp   <= next_exp;
        out_mant  <= next_mant;
        out_guard <= next_guard;
      end
    end
  end
endmodule

// File: rtl/dnorm_shift_chk.sv
module dnorm_shift_chk #(
  parameter int MW = 64,
  parameter int GW = 8,
  parameter int EW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [EW-1:0] in_exp,
  input logic [MW-1:0] in_mant,
  input logic [CW-1:0] in_cnt,
  input logic          band_collapse,
  input logic          band_sticky,
  input logic          sticky_bit,
  input logic          out_valid,
  input logic [EW-1:0] out_exp,
  input logic [MW-1:0] out_mant,
  input logic [GW-1:0] out_guard
);
  localparam int HALF = MW / 2;

  // R1
  exp_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_exp == $past(in_exp + EW'(in_cnt)));

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_mant) && $stable(out_guard));

  // R2
  zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_cnt == '0 |=> out_mant == $past(in_mant) && out_guard == '0);

  // R3
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && band_sticky && sticky_bit |=> out_guard[0]);

  // R4
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && int'(in_cnt) > HALF && !band_collapse |=> out_mant[MW-1:HALF] == '0);

  // R6
  collapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && band_collapse |=> out_mant == '0 && out_guard == GW'($past(in_mant) != '0));
endmodule

bind dnorm_shift_unit dnorm_shift_chk #(.MW(MW), .GW(GW), .EW(EW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_exp        (in_exp),
  .in_mant       (in_mant),
  .in_cnt        (in_cnt),
  .band_collapse (band_collapse),
  .band_sticky   (band_sticky),
  .sticky_bit    (sticky_bit),
  .out_valid     (out_valid),
  .out_exp       (out_exp),
  .out_mant      (out_mant),
  .out_guard     (out_guard)
);

// File: tb/sim_dnorm_shift_unit.sv
module sim_dnorm_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_exp = '0;
  logic [63:0] in_mant = '0;
  logic [7:0]  in_guard = '0;
  logic [15:0] in_cnt = '0;
  logic        out_valid;
  logic [15:0] out_exp;
  logic [63:0] out_mant;
  logic [7:0]  out_guard;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dnorm_shift_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_exp(in_exp),
    .in_mant(in_mant), .in_guard(in_guard), .in_cnt(in_cnt),
    .out_valid(out_valid), .out_exp(out_exp), .out_mant(out_mant),
    .out_guard(out_guard)
  );

  task automatic check(input string req, input logic [87:0] got, input logic [87:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, want);
    end
  endtask

  // Bit-serial model: one step per count, tracking the bit that
  // leaves the guard window in a running sticky flag.
  task automatic model(input logic [63:0] m, input logic [15:0] c,
                       output logic [63:0] mo, output logic [7:0] go);
    logic [71:0] span;
    logic        stk;
    if (c >= 16'd72) begin
      mo = '0;
      go = (m != 0) ? 8'd1 : 8'd0;
    end else begin
      span = {m, 8'h00};
      stk  = 1'b0;
      for (int k = 0; k < int'(c); k++) begin
        stk  = stk | span[0];
        span = {1'b0, span[71:1]};
      end
      mo = span[71:8];
      go = span[7:0];
      if (c > 16'd8) go[0] = go[0] | stk;
    end
  endtask

  task automatic run_one(input string req, input logic [15:0] e,
                         input logic [63:0] m, input logic [7:0] g,
                         input logic [15:0] c);
    logic [63:0] wm;
    logic [7:0]  wg;
    model(m, c, wm, wg);
    @(negedge clk);
    in_valid = 1'b1; in_exp = e; in_mant = m; in_guard = g; in_cnt = c;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid R8"}, 88'(out_valid), 88'(1));
    check({req, " exp R1"}, 88'(out_exp), 88'(16'(e + c)));
    check({req, " mant"}, 88'(out_mant), 88'(wm));
    check({req, " guard"}, 88'(out_guard), 88'(wg));
  endtask

  task automatic t_reset;
    check("R9 valid", 88'(out_valid), 88'(0));
    check("R9 data", {out_exp, out_mant, out_guard}, 88'(0));
  endtask

  task automatic t_exact;
    run_one("R2 cnt0", 16'h3FFF, 64'hDEAD_BEEF_0123_4567, 8'h00, 16'd0);
    run_one("R2 cnt4", 16'h0100, 64'h8000_0000_0000_000F, 8'h00, 16'd4);
    run_one("R2 cnt8", 16'h0100, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 16'd8);
  endtask

  task automatic t_sticky;
    run_one("R3 cnt9", 16'h0010, 64'h8000_0000_0000_0001, 8'h00, 16'd9);
    run_one("R3 cnt20", 16'h0010, 64'h1234_5678_9ABC_DEF0, 8'h00, 16'd20);
    run_one("R3 cnt32", 16'h0010, 64'hCAFE_0000_0000_0100, 8'h00, 16'd32);
    run_one("R4 cnt33", 16'h0020, 64'hF0F0_F0F0_0000_0003, 8'h00, 16'd33);
    run_one("R4 cnt39", 16'h0020, 64'hFFFF_FFFF_8000_0000, 8'h00, 16'd39);
    run_one("R5 cnt40", 16'h0020, 64'h8000_0000_0000_0001, 8'h00, 16'd40);
    run_one("R5 cnt64", 16'h0020, 64'h8000_0000_0001_0000, 8'h00, 16'd64);
    run_one("R5 cnt71", 16'h0020, 64'h8000_0000_0000_0000, 8'h00, 16'd71);
    run_one("R3 clean", 16'h0020, 64'hFF00_0000_0000_0000, 8'h00, 16'd50);
  endtask

  task automatic t_collapse;
    run_one("R6 cnt72", 16'h0001, 64'h0000_0000_0000_0001, 8'h00, 16'd72);
    run_one("R6 cnt200", 16'h0001, 64'h8000_0000_0000_0000, 8'h00, 16'd200);
    run_one("R6 max", 16'h0001, 64'h0000_0400_0000_0000, 8'h00, 16'hFFFF);
    run_one("R6 zero", 16'h0001, 64'h0, 8'h00, 16'd90);
  endtask

  task automatic t_wrap;
    run_one("R1 wrap", 16'hFFF0, 64'h1, 8'h00, 16'h0020);
  endtask

  task automatic t_guard_ignored;
    run_one("R7 g small", 16'h0005, 64'hA5A5_A5A5_A5A5_A5A5, 8'hFF, 16'd3);
    run_one("R7 g sticky", 16'h0005, 64'hFF00_0000_0000_0000, 8'hFF, 16'd30);
    run_one("R7 g collapse", 16'h0005, 64'h0, 8'hFF, 16'd100);
  endtask

  task automatic t_hold;
    logic [63:0] m0;
    logic [7:0]  g0;
    logic [15:0] e0;
    run_one("R8 pre", 16'h0042, 64'h0123_4567_89AB_CDEF, 8'h00, 16'd12);
    m0 = out_mant; g0 = out_guard; e0 = out_exp;
    @(negedge clk);
    in_exp = 16'h7777; in_mant = 64'hFFFF; in_cnt = 16'd1;
    @(negedge clk);
    check("R8 idle valid", 88'(out_valid), 88'(0));
    check("R8 idle hold", {out_exp, out_mant, out_guard}, {e0, m0, g0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_exact();
    t_sticky();
    t_collapse();
    t_wrap();
    t_guard_ignored();
    t_hold();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule